// File: doc/BRIEF.md
# Burst Length and Pattern Generator

This block answers each request pulse with a burst of 16-bit data words, one word per clock. The burst length is worked out once, when the request is accepted. It comes either from a fixed length input or from a pseudo-random source, with the random value cut down by a mask. The block then raises the length to at least two words. Unless rounding is disabled, it also rounds the length up to the next multiple of three.

Each word comes from one of three sources: a running sequential count, a pseudo-random sequence, or a constant input word. Every word carries a valid strobe, a last flag and a continue flag. A force input sets the continue flag on every word, the final one included, so a consumer that ends bursts on a missing continue never ends the burst early.

The control is a two-state machine. `S_IDLE` waits for a request. The START transition (S_IDLE with `req` high) loads the length and the configuration. HOLD (S_BURST with more than one word left) emits a word and counts down. FINISH (S_BURST with one word left) emits the final word and returns to S_IDLE.

Top module: `bg_burst_gen`

## Requirements
- R1: After reset `word_valid`, `word_last` and `word_cont` are 0. The sequential count is 0, the data generator holds 0xACE1 and the length generator holds 0x1D2B.
- R2: With `rand_len_en`=0 the base length is `len_reg`. With `rand_len_en`=1 it is the length generator's state ANDed with the inverse of `len_mask`. The length generator advances once per accepted request, using next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R3: A base length below 2 is raised to 2.
- R4: With `no_round`=0 the length, after the minimum is applied, is rounded up to the next multiple of 3. With `no_round`=1 it is used unchanged.
- R5: `pat_sel`=01 gives sequential data: the count starts at 0 after reset, adds 1 per sequential word, wraps at 16 bits and carries over between bursts. `pat_sel`=10 gives the data generator's state, which uses the same next-state rule as R2 and advances once per pseudo-random word. `pat_sel`=00 or 11 gives `const_word`.
- R6: `word_cont` is 1 on every word when `force_cont`=1. When `force_cont`=0 it is 1 on every word except the last, where it is 0.
- R7: A request is accepted only while `word_valid` is 0. The first word appears on the cycle after acceptance, and words follow back to back. `word_last` is high only on the final word, and `word_valid` is 0 on the cycle after it.
- R8: The length, `pat_sel`, `force_cont` and `const_word` are sampled when a request is accepted. Requests and configuration changes during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Burst request pulse |
| rand_len_en | input | 1 | 1 selects the masked random length |
| no_round | input | 1 | 0 rounds the length up to a multiple of 3 |
| force_cont | input | 1 | 1 sets the continue flag on every word |
| pat_sel | input | 2 | Data source: 01 sequential, 10 pseudo-random, else constant |
| len_reg | input | 16 | Fixed burst length |
| len_mask | input | 16 | Set bits clear the matching random length bits |
| const_word | input | 16 | Constant data word |
| word_valid | output | 1 | Data word valid |
| word_data | output | 16 | Data word |
| word_last | output | 1 | Final word of the burst |
| word_cont | output | 1 | Continue response flag |

## Verification
A wrong remaining-word count shows in the word count of the same burst: `word_last` comes too early or too late, or the burst length breaks the minimum or the multiple-of-three rule at the final word. A corrupted sequential count or data generator state shows on the next word that uses that source. Because the sequential count carries over between bursts, an error in it also shows in the first word of a later sequential burst. A stuck state register shows as a missing first word one cycle after a request, or as `word_valid` still high on the cycle after the final word.

// File: rtl/bg_pkg.sv
package bg_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } bg_state_e;

    typedef enum logic [1:0] {
        PAT_FIX0 = 2'b00,
        PAT_SEQ  = 2'b01,
        PAT_PRBS = 2'b10,
        PAT_FIX1 = 2'b11
    } bg_pat_e;
endpackage

// File: rtl/bg_lfsr.sv
module bg_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] state
);
    logic feedback;

    assign feedback = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (step) begin
            state <= {state[WIDTH-2:0], feedback};
        end
    end
endmodule

// File: rtl/bg_len_calc.sv
module bg_len_calc #(
    parameter int LEN_W = 16,
    localparam int OUT_W = LEN_W + 2
) (
    input  logic [LEN_W-1:0] len_reg,
    input  logic [LEN_W-1:0] len_mask,
    input  logic [LEN_W-1:0] rnd,
    input  logic             rand_len_en,
    input  logic             no_round,
    output logic [OUT_W-1:0] len_out
);
    logic [OUT_W-1:0] base_len;
    logic [OUT_W-1:0] min_len;
    logic [OUT_W-1:0] up_len;

    always_comb begin
        // masking first, then the floor of two, then rounding
        if (rand_len_en) begin
            base_len = {2'b00, rnd & ~len_mask};
        end else begin
            base_len = {2'b00, len_reg};
        end
        min_len = (base_len < OUT_W'(2)) ? OUT_W'(2) : base_len;
        up_len  = ((min_len + OUT_W'(2)) / OUT_W'(3)) * OUT_W'(3);
        len_out = no_round ? min_len : up_len;
    end
endmodule

// File: rtl/bg_burst_gen.sv
module bg_burst_gen
    import bg_pkg::*;
#(
    parameter int               LEN_W     = 16,
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] DATA_SEED = 16'hACE1,
    parameter logic [LEN_W-1:0]  LEN_SEED  = 16'h1D2B,
    parameter logic [DATA_W-1:0] DATA_TAPS = 16'hB400,
    parameter logic [LEN_W-1:0]  LEN_TAPS  = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rand_len_en,
    input  logic              no_round,
    input  logic              force_cont,
    input  logic [1:0]        pat_sel,
    input  logic [LEN_W-1:0]  len_reg,
    input  logic [LEN_W-1:0]  len_mask,
    input  logic [DATA_W-1:0] const_word,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic              word_last,
    output logic              word_cont
);
    localparam int CNT_W = LEN_W + 2;

    bg_state_e         state_q, state_d;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  new_len;
    bg_pat_e           pat_q;
    logic              force_q;
    logic [DATA_W-1:0] const_q;
    logic [DATA_W-1:0] seq_q;
    logic [DATA_W-1:0] prbs_state;
    logic [LEN_W-1:0]  len_rnd;
    logic              accept;
    logic              final_word;
    logic              prbs_step;

    assign accept     = (state_q == S_IDLE) && req;
    assign final_word = (state_q == S_BURST) && (remain_q == CNT_W'(1));
    assign prbs_step  = (state_q == S_BURST) && (pat_q == PAT_PRBS);

    bg_lfsr #(.WIDTH(LEN_W), .TAPS(LEN_TAPS), .SEED(LEN_SEED)) u_len_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .state (len_rnd)
    );

    bg_lfsr #(.WIDTH(DATA_W), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_data_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (prbs_step),
        .state (prbs_state)
    );

    bg_len_calc #(.LEN_W(LEN_W)) u_len_calc (
        .len_reg     (len_reg),
        .len_mask    (len_mask),
        .rnd         (len_rnd),
        .rand_len_en (rand_len_en),
        .no_round    (no_round),
        .len_out     (new_len)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req) state_d = S_BURST;          // START
            S_BURST: if (final_word) state_d = S_IDLE;    // FINISH, else HOLD
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // burst counter and sampled configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            pat_q    <= PAT_FIX0;
            force_q  <= 1'b0;
            const_q  <= '0;
            seq_q    <= '0;
        end else if (accept) begin
            remain_q <= new_len;
            pat_q    <= bg_pat_e'(pat_sel);
            force_q  <= force_cont;
            const_q  <= const_word;
        end else if (state_q == S_BURST) begin
            remain_q <= remain_q - CNT_W'(1);
            if (pat_q == PAT_SEQ) begin
                seq_q <= seq_q + DATA_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        word_valid = 1'b0;
        word_last  = 1'b0;
        word_cont  = 1'b0;
        word_data  = '0;
        unique case (state_q)
            S_IDLE: begin
                word_valid = 1'b0;
            end
            S_BURST: begin
                word_valid = 1'b1;
                word_last  = final_word;
                word_cont  = force_q || !final_word;
                unique case (pat_q)
                    PAT_SEQ:  word_data = seq_q;
                    PAT_PRBS: word_data = prbs_state;
                    default:  word_data = const_q;
                endcase
            end
            default: word_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/bg_burst_chk.sv
module bg_burst_chk #(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              no_round,
    input logic              force_cont,
    input logic [1:0]        pat_sel,
    input logic              word_valid,
    input logic [DATA_W-1:0] word_data,
    input logic              word_last,
    input logic              word_cont
);
    localparam int CNT_W = LEN_W + 2;

    logic [CNT_W-1:0] seen;
    logic             cap_no_round;
    logic             cap_force;
    logic [1:0]       cap_pat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen         <= '0;
            cap_no_round <= 1'b1;
            cap_force    <= 1'b0;
            cap_pat      <= 2'b00;
        end else begin
            if (req && !word_valid) begin
                cap_no_round <= no_round;
                cap_force    <= force_cont;
                cap_pat      <= pat_sel;
            end
            if (word_valid && !word_last) begin
                seen <= seen + CNT_W'(1);
            end else begin
                seen <= '0;
            end
        end
    end

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> word_valid);                                           // R7
    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |=> !word_valid);                                          // R7
    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(req));                                   // R7
    AST_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> (seen >= CNT_W'(1)));                                  // R3
    AST_ROUND_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_last && !cap_no_round) |-> (((seen + CNT_W'(1)) % CNT_W'(3)) == CNT_W'(0))); // R4
    AST_FORCED_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cap_force) |-> word_cont);                            // R6
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && (seen != '0) && (cap_pat == 2'b01)) |->
            (word_data == $past(word_data) + DATA_W'(1)));                   // R5
endmodule

bind bg_burst_gen bg_burst_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_bg_burst_chk (.*);

// File: tb/test_bg_burst_gen.sv
module test_bg_burst_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rand_len_en = 1'b0;
    logic        no_round = 1'b1;
    logic        force_cont = 1'b0;
    logic [1:0]  pat_sel = 2'b01;
    logic [15:0] len_reg = 16'd4;
    logic [15:0] len_mask = 16'hFFFF;
    logic [15:0] const_word = 16'h0000;
    logic        word_valid;
    logic [15:0] word_data;
    logic        word_last;
    logic        word_cont;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [15:0] seq_m  = 16'h0000;
    logic [15:0] prbs_m = 16'hACE1;
    logic [15:0] lenr_m = 16'h1D2B;

    logic [15:0] got_data [0:63];
    logic        got_last [0:63];
    logic        got_cont [0:63];
    int          got_n;

    always #2.5 clk = ~clk;

    bg_burst_gen i_bg_burst_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .rand_len_en(rand_len_en),
        .no_round(no_round), .force_cont(force_cont), .pat_sel(pat_sel),
        .len_reg(len_reg), .len_mask(len_mask), .const_word(const_word),
        .word_valid(word_valid), .word_data(word_data),
        .word_last(word_last), .word_cont(word_cont)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int exp_len(input bit rnd_en, input logic [15:0] lr,
                                   input logic [15:0] msk, input bit nr,
                                   input logic [15:0] rs);
        int v;
        v = rnd_en ? int'(rs & ~msk) : int'(lr);
        if (v < 2) v = 2;
        if (!nr) v = ((v + 2) / 3) * 3;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // request a burst and record it; poke_at >= 0 drives a stray request and
    // new configuration at that word index
    task automatic do_burst(input int poke_at);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        lenr_m = lfsr_next(lenr_m);
        got_n = 0;
        while (word_valid && got_n < 64) begin
            got_data[got_n] = word_data;
            got_last[got_n] = word_last;
            got_cont[got_n] = word_cont;
            got_n++;
            if (got_n - 1 == poke_at) begin
                req = 1'b1;
                pat_sel = 2'b00;
                const_word = 16'hDEAD;
                force_cont = ~force_cont;
                len_reg = 16'd30;
            end
            if (got_last[got_n-1]) break;
            @(negedge clk);
            req = 1'b0;
        end
        req = 1'b0;
        @(negedge clk);
        check(word_valid == 1'b0, "R7 valid low after last", int'(word_valid), 0);
    endtask

    task automatic verify_burst(input string tag, input int n_exp, input logic [1:0] pat,
                                input logic [15:0] cst, input bit frc);
        check(got_n == n_exp, {tag, " length"}, got_n, n_exp);
        for (int i = 0; i < got_n; i++) begin
            logic [15:0] e;
            bit el;
            if (pat == 2'b01) begin
                e = seq_m;
                seq_m = seq_m + 16'd1;
            end else if (pat == 2'b10) begin
                e = prbs_m;
                prbs_m = lfsr_next(prbs_m);
            end else begin
                e = cst;
            end
            el = (i == n_exp - 1);
            check(got_data[i] == e, {tag, " R5 data"}, int'(got_data[i]), int'(e));
            check(got_last[i] == el, {tag, " R7 last"}, int'(got_last[i]), int'(el));
            check(got_cont[i] == (frc || !el), {tag, " R6 cont"}, int'(got_cont[i]), int'(frc || !el));
        end
    endtask

    task automatic set_cfg(input bit rnd, input bit nr, input bit frc, input logic [1:0] p,
                           input logic [15:0] lr, input logic [15:0] msk, input logic [15:0] cw);
        @(negedge clk);
        rand_len_en = rnd; no_round = nr; force_cont = frc; pat_sel = p;
        len_reg = lr; len_mask = msk; const_word = cw;
    endtask

    task automatic t_reset();
        check(word_valid == 1'b0, "R1 valid at reset", int'(word_valid), 0);
        check(word_last == 1'b0, "R1 last at reset", int'(word_last), 0);
        check(word_cont == 1'b0, "R1 cont at reset", int'(word_cont), 0);
    endtask

    task automatic t_fixed_seq();
        int n;
        set_cfg(1'b0, 1'b1, 1'b0, 2'b01, 16'd5, 16'hFFFF, 16'h0);
        n = exp_len(1'b0, 16'd5, 16'hFFFF, 1'b1, lenr_m);
        do_burst(-1);
        verify_burst("R2 fixed seq", n, 2'b01, 16'h0, 1'b0);
        check(got_data[0] == 16'h0000, "R1 seq starts at 0", int'(got_data[0]), 0);
    endtask

    task automatic t_min_two();
        set_cfg(1'b0, 1'b1, 1'b0, 2'b01, 16'd0, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R3 len0", 2, 2'b01, 16'h0, 1'b0);
        set_cfg(1'b0, 1'b1, 1'b0, 2'b01, 16'd1, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R3 len1", 2, 2'b01, 16'h0, 1'b0);
    endtask

    task automatic t_round();
        set_cfg(1'b0, 1'b0, 1'b0, 2'b00, 16'd4, 16'hFFFF, 16'h5A5A);
        do_burst(-1);
        verify_burst("R4 len4", 6, 2'b00, 16'h5A5A, 1'b0);
        set_cfg(1'b0, 1'b0, 1'b0, 2'b01, 16'd1, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R4 len1", 3, 2'b01, 16'h0, 1'b0);
        set_cfg(1'b0, 1'b0, 1'b0, 2'b11, 16'd9, 16'hFFFF, 16'h1234);
        do_burst(-1);
        verify_burst("R4 len9", 9, 2'b11, 16'h1234, 1'b0);
    endtask

    task automatic t_prbs();
        set_cfg(1'b0, 1'b1, 1'b0, 2'b10, 16'd7, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R5 prbs", 7, 2'b10, 16'h0, 1'b0);
        set_cfg(1'b0, 1'b1, 1'b0, 2'b01, 16'd3, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R5 seq resumes", 3, 2'b01, 16'h0, 1'b0);
    endtask

    task automatic t_random_len();
        int n;
        set_cfg(1'b1, 1'b1, 1'b0, 2'b01, 16'd40, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R2 rand full mask", 2, 2'b01, 16'h0, 1'b0);
        set_cfg(1'b1, 1'b1, 1'b0, 2'b01, 16'd40, 16'hFFF0, 16'h0);
        n = exp_len(1'b1, 16'd40, 16'hFFF0, 1'b1, lenr_m);
        do_burst(-1);
        verify_burst("R2 rand mask fff0", n, 2'b01, 16'h0, 1'b0);
        set_cfg(1'b1, 1'b0, 1'b0, 2'b10, 16'd40, 16'hFFE0, 16'h0);
        n = exp_len(1'b1, 16'd40, 16'hFFE0, 1'b0, lenr_m);
        do_burst(-1);
        verify_burst("R2 R4 rand rounded", n, 2'b10, 16'h0, 1'b0);
    endtask

    task automatic t_force_cont();
        set_cfg(1'b0, 1'b1, 1'b1, 2'b01, 16'd4, 16'hFFFF, 16'h0);
        do_burst(-1);
        verify_burst("R6 forced", 4, 2'b01, 16'h0, 1'b1);
    endtask

    task automatic t_ignore();
        set_cfg(1'b0, 1'b1, 1'b0, 2'b01, 16'd6, 16'hFFFF, 16'h0);
        do_burst(2);
        verify_burst("R8 mid-burst changes", 6, 2'b01, 16'h0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(word_valid == 1'b0, "R8 stray request ignored", int'(word_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_seq();
        t_min_two();
        t_round();
        t_prbs();
        t_random_len();
        t_force_cont();
        t_ignore();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule